// File: doc/BRIEF.md
# Paged RAM Address Generator

This block produces the 15-bit address for a 32K x 8 data memory. The low address byte is either the instruction's immediate byte or the index register X. The high part is either zero, which selects page zero, or the low seven bits of the page register Y. A 2-bit address-form select, driven by the instruction decoder, picks one of four combinations. The address output is combinational, so it is valid in the same cycle as the select.

The block owns the X and Y registers. Each one loads from the datapath result when the decoder asserts its load strobe. X also has a post-increment: when the decoder requests it together with the paged-index form, the access in that cycle uses the current X, and X steps by one at the clock edge that ends the cycle. This gives a cheap pointer for streaming bytes along a row, for example pixels. The increment wraps within the byte and does not carry into Y.

Top module: `ppage_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, X and Y read 0 until they are first loaded.
- R2: With `addr_form` = 0 (page zero, immediate), `ram_addr` = {7'b0, `imm_byte`} in the same cycle.
- R3: With `addr_form` = 1 (page zero, indexed), `ram_addr` = {7'b0, X}.
- R4: With `addr_form` = 2 (paged, immediate), `ram_addr` = {Y[6:0], `imm_byte`}.
- R5: With `addr_form` = 3 (paged, indexed), `ram_addr` = {Y[6:0], X}.
- R6: Y bit 7 never reaches `ram_addr`. Two values of Y that differ only in bit 7 give the same address.
- R7: `x_load` and `y_load` copy `wr_data` into X and Y respectively at the next rising edge. A register whose strobe is low keeps its value, unless R8 applies to it.
- R8: When `post_inc` is high, `addr_form` = 3 and `x_load` is low, X becomes X+1 at the next edge. The address in that cycle uses the old X.
- R9: The increment wraps X from 0xFF to 0x00 and leaves Y unchanged.
- R10: When `x_load` and a valid increment are requested in the same cycle, X takes `wr_data`.
- R11: `post_inc` has no effect on X when `addr_form` is 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_form | input | 2 | Address form: 0 = zero/imm, 1 = zero/X, 2 = Y/imm, 3 = Y/X |
| post_inc | input | 1 | Request to increment X after the access (only honoured in form 3) |
| imm_byte | input | 8 | Immediate low address byte |
| wr_data | input | 8 | Result value for loading X or Y |
| x_load | input | 1 | Load X from `wr_data` |
| y_load | input | 1 | Load Y from `wr_data` |
| ram_addr | output | 15 | RAM address |
| x_value | output | 8 | Current X |
| y_value | output | 8 | Current Y |

## Verification
The bench goes after the 0xFF-to-0x00 wrap of X. A design that lets the carry ripple into Y would move the streaming pointer to the next page. It sets Y bit 7 in the paged forms, where a design that used all eight bits of Y would form an address outside the 15-bit range. It collides a load of X with an increment, where the wrong priority gives X+1 instead of the loaded value. It also requests an increment in the three non-indexed-paged forms, where a design that does not gate the request would move X. Random traffic also checks that the address in an increment cycle is built from the old X, not the new one.

// File: rtl/ppage_pkg.sv
package ppage_pkg;
    typedef enum logic [1:0] {
        FORM_ZP_IMM = 2'd0,
        FORM_ZP_IDX = 2'd1,
        FORM_PG_IMM = 2'd2,
        FORM_PG_IDX = 2'd3
    } addr_form_e;
endpackage

// File: rtl/ppage_xreg.sv
module ppage_xreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              step_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] nxt;

    // The load has priority over the step; the step wraps within DATA_W bits.
    always_comb begin
        if (load_en)      nxt = load_val;
        else if (step_en) nxt = q + DATA_W'(1);
        else              nxt = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/ppage_yreg.sv
module ppage_yreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= load_val;
    end
endmodule

// File: rtl/ppage_mux.sv
module ppage_mux
    import ppage_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input  addr_form_e        form,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] xv,
    input  logic [DATA_W-1:0] yv,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAGE_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] lo;
    logic [PAGE_W-1:0] hi;

    always_comb begin
        unique case (form)
            FORM_ZP_IMM: begin lo = imm; hi = '0;             end
            FORM_ZP_IDX: begin lo = xv;  hi = '0;             end
            FORM_PG_IMM: begin lo = imm; hi = yv[PAGE_W-1:0]; end
            FORM_PG_IDX: begin lo = xv;  hi = yv[PAGE_W-1:0]; end
            default:     begin lo = imm; hi = '0;             end
        endcase
    end

    assign addr = {hi, lo};
endmodule

// File: rtl/ppage_addr_gen.sv
module ppage_addr_gen
    import ppage_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_form,
    input  logic              post_inc,
    input  logic [DATA_W-1:0] imm_byte,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              x_load,
    input  logic              y_load,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] x_value,
    output logic [DATA_W-1:0] y_value
);
    addr_form_e form;
    logic       step_x;

    assign form   = addr_form_e'(addr_form);
    assign step_x = post_inc && (form == FORM_PG_IDX);

    ppage_xreg #(.DATA_W(DATA_W)) u_xreg (
        .clk(clk), .rst_n(rst_n), .load_en(x_load), .step_en(step_x),
        .load_val(wr_data), .q(x_value)
    );

    ppage_yreg #(.DATA_W(DATA_W)) u_yreg (
        .clk(clk), .rst_n(rst_n), .load_en(y_load),
        .load_val(wr_data), .q(y_value)
    );

    ppage_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
        .form(form), .imm(imm_byte), .xv(x_value), .yv(y_value), .addr(ram_addr)
    );
endmodule

// File: rtl/ppage_addr_gen_chk.sv
module ppage_addr_gen_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr_form,
    input logic              post_inc,
    input logic [DATA_W-1:0] imm_byte,
    input logic [DATA_W-1:0] wr_data,
    input logic              x_load,
    input logic              y_load,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] x_value,
    input logic [DATA_W-1:0] y_value
);
    localparam int PAGE_W = ADDR_W - DATA_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (x_value == '0 && y_value == '0));

    assert_zero_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_form[1] == 1'b0) |-> (ram_addr[ADDR_W-1:DATA_W] == '0));

    assert_paged_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_form[1] == 1'b1) |-> (ram_addr[ADDR_W-1:DATA_W] == y_value[PAGE_W-1:0]));

    assert_x_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        x_load |=> (x_value == $past(wr_data)));

    assert_y_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !y_load |=> $stable(y_value));

    assert_post_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (post_inc && addr_form == 2'd3 && !x_load)
            |=> (x_value == DATA_W'($past(x_value) + DATA_W'(1))));

    assert_wrap_no_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (post_inc && addr_form == 2'd3 && !x_load && !y_load && x_value == '1)
            |=> (x_value == '0 && $stable(y_value)));

    assert_inc_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_form != 2'd3 && !x_load) |=> $stable(x_value));
endmodule

bind ppage_addr_gen ppage_addr_gen_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ppage_addr_gen_test.sv
module ppage_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr_form = 2'd0;
    logic        post_inc = 1'b0;
    logic [7:0]  imm_byte = 8'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        x_load = 1'b0;
    logic        y_load = 1'b0;
    logic [14:0] ram_addr;
    logic [7:0]  x_value;
    logic [7:0]  y_value;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] mx = 8'd0;
    logic [7:0] my = 8'd0;

    always #4 clk = ~clk;

    ppage_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .addr_form(addr_form), .post_inc(post_inc),
        .imm_byte(imm_byte), .wr_data(wr_data), .x_load(x_load), .y_load(y_load),
        .ram_addr(ram_addr), .x_value(x_value), .y_value(y_value)
    );

    function automatic logic [14:0] exp_addr(input logic [1:0] f, input logic [7:0] d,
                                             input logic [7:0] x, input logic [7:0] y);
        logic [7:0] lo;
        logic [6:0] hi;
        lo = f[0] ? x : d;
        hi = f[1] ? y[6:0] : 7'd0;
        return {hi, lo};
    endfunction

    function automatic string addr_tag(input logic [1:0] f, input logic [7:0] y);
        if (f[1] && y[7]) return "R6";
        case (f)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] f, input logic inc, input logic [7:0] d,
                        input logic [7:0] res, input logic lx, input logic ly);
        string xtag;
        logic  valid_inc;
        @(negedge clk);
        addr_form = f; post_inc = inc; imm_byte = d; wr_data = res;
        x_load = lx; y_load = ly;
        #1;
        // The address uses the X held before any increment (R8).
        check(addr_tag(f, my), 32'(ram_addr), 32'(exp_addr(f, d, mx, my)));
        valid_inc = inc && (f == 2'd3);
        if (lx && valid_inc)          xtag = "R10";
        else if (lx)                  xtag = "R7";
        else if (valid_inc && mx == 8'hFF) xtag = "R9";
        else if (valid_inc)           xtag = "R8";
        else if (inc)                 xtag = "R11";
        else                          xtag = "R7";
        if (lx)             mx = res;
        else if (valid_inc) mx = mx + 8'd1;
        if (ly)             my = res;
        @(posedge clk);
        #1;
        check(xtag, 32'(x_value), 32'(mx));
        check((valid_inc && !ly) ? "R9" : "R7", 32'(y_value), 32'(my));
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #20;
        check("R1", 32'(x_value), 32'd0);
        check("R1", 32'(y_value), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 32'(x_value), 32'd0);
        check("R1", 32'(y_value), 32'd0);

        // Directed corner cases
        step(2'd0, 1'b0, 8'h5A, 8'hFD, 1'b1, 1'b0);  // R7: load X
        step(2'd0, 1'b0, 8'h11, 8'hC3, 1'b0, 1'b1);  // R7: load Y with bit 7 set
        step(2'd2, 1'b0, 8'h22, 8'h00, 1'b0, 1'b0);  // R4, R6
        step(2'd3, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);  // R5, R8: FD -> FE
        step(2'd3, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);  // R8: FE -> FF
        step(2'd3, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);  // R9: wrap FF -> 00, Y kept
        step(2'd1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);  // R3
        step(2'd3, 1'b1, 8'h00, 8'h77, 1'b1, 1'b0);  // R10: load beats increment
        step(2'd0, 1'b1, 8'h33, 8'h00, 1'b0, 1'b0);  // R11
        step(2'd1, 1'b1, 8'h33, 8'h00, 1'b0, 1'b0);  // R11
        step(2'd2, 1'b1, 8'h33, 8'h00, 1'b0, 1'b0);  // R11
        step(2'd0, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0);  // R2

        // Constrained random traffic, increments weighted up
        for (int i = 0; i < 400; i++) begin
            logic [1:0] f;
            f = 2'($urandom);
            step(f, ($urandom % 3) != 0, 8'($urandom), 8'($urandom),
                 ($urandom % 6) == 0, ($urandom % 5) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule